// File: doc/BRIEF.md
# Predisplay Interrupt and Flag Generator

This block watches the scanline number supplied by a PAL video line counter and marks the predisplay interval for the main processor. It drives the processor's interrupt request and the level sampled on the processor's first external flag pin. The parameter `VARIANT` selects one of two behaviours. In the interrupt variant, the interrupt and an active-high flag are raised on the scanline where predisplay starts and dropped on the scanline where it ends. In the flag-only variant, no interrupt is ever raised and the flag runs active-low over the same interval.

The block also packs the 4-bit external flag bus. It places the predisplay flag in bit 0 and passes the active-low test and coin inputs into the upper bits. Finally, it produces the processor's mode code. The code holds the processor in reset for a fixed power-up window, which is `BOOT_CYCLES` clocks and sized for 200 ms at the system clock. After that window the code switches to run. A synchronous reset puts the mode back to hold and starts the window over.

All pins are plain control and status levels. Nothing in this block moves a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `prd_event_unit`

## Requirements
- R1: With `VARIANT` set to raise an interrupt, a cycle in which `scanline_i` equals `PRD_START` makes `irq_o` 1 and `ef_o[0]` 1 from the next clock edge.
- R2: With `VARIANT` set to raise an interrupt, a cycle in which `scanline_i` equals `PRD_END` makes `irq_o` 0 and `ef_o[0]` 0 from the next clock edge.
- R3: With `VARIANT` set to flag-only, `irq_o` is 0 at all times.
- R4: With `VARIANT` set to flag-only, a cycle on `PRD_START` makes `ef_o[0]` 0 from the next edge, and a cycle on `PRD_END` makes it 1 from the next edge.
- R5: Scanline values other than `PRD_START` and `PRD_END` have no effect on `irq_o` or `ef_o[0]`. Both keep their values from the previous cycle.
- R6: `ef_o[3]` equals `coin1_n_i`, `ef_o[2]` equals `coin2_n_i` and `ef_o[1]` equals `test_n_i`, with no inversion and no clock delay.
- R7: `mode_o` is 2'b01 (hold in reset) until `BOOT_CYCLES` clock edges have occurred with `rst` low. It then becomes 2'b11 (run) and stays 2'b11 until the next reset.
- R8: With `rst` high at a clock edge, the following state holds from that edge: `mode_o` is 2'b01, `irq_o` is 0, and `ef_o[0]` is 0 in the interrupt variant or 1 in the flag-only variant. The power-up window then restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| scanline_i | input | SCAN_W | Current scanline number from the video line counter |
| test_n_i | input | 1 | Test switch, active low |
| coin1_n_i | input | 1 | First coin input, active low |
| coin2_n_i | input | 1 | Second coin input, active low |
| irq_o | output | 1 | Interrupt request to the processor, active high |
| ef_o | output | 4 | External flag bus: bit 0 predisplay flag, bits 3..1 coin 1, coin 2, test |
| mode_o | output | 2 | Processor mode code: 2'b01 hold in reset, 2'b11 run |

## Verification
The case hardest to reach from the ports is a reset that lands while the power-up window is running, or while the predisplay flag is in its active state. It must clear the flag, withdraw run mode and restart the window, and none of this shows up unless the run has first crossed the window's edge. The bench shrinks the window to a few dozen clocks and the frame to 32 lines, then sweeps whole frames past the transition to run. It then asserts reset inside the predisplay interval and counts the window again cycle by cycle. Running both variants side by side on the same scanline stream exposes any polarity mix-up between them.

// File: rtl/prd_pkg.sv
package prd_pkg;

  typedef enum logic {
    PRD_RAISE_IRQ = 1'b0,
    PRD_FLAG_ONLY = 1'b1
  } prd_variant_e;

  localparam logic [1:0] MODE_HOLD = 2'b01;
  localparam logic [1:0] MODE_RUN  = 2'b11;

  typedef struct packed {
    logic hit_start;
    logic hit_end;
  } prd_hits_t;

endpackage

// File: rtl/prd_line_match.sv
module prd_line_match #(
  parameter int SCAN_W    = 9,
  parameter int PRD_START = 283,
  parameter int PRD_END   = 301
) (
  input  logic [SCAN_W-1:0] scanline_i,
  output prd_pkg::prd_hits_t hits_o
);
  localparam logic [SCAN_W-1:0] START_L = SCAN_W'(PRD_START);
  localparam logic [SCAN_W-1:0] END_L   = SCAN_W'(PRD_END);

  always_comb begin
    hits_o.hit_start = (scanline_i == START_L);
    hits_o.hit_end   = (scanline_i == END_L);
  end
endmodule

// File: rtl/prd_edge_state.sv
module prd_edge_state #(
  parameter prd_pkg::prd_variant_e VARIANT = prd_pkg::PRD_RAISE_IRQ
) (
  input  logic               clk,
  input  logic               rst,
  input  prd_pkg::prd_hits_t hits_i,
  output logic               flag_o,
  output logic               irq_o
);
  generate
    if (VARIANT == prd_pkg::PRD_RAISE_IRQ) begin : g_irq
      logic flag_q;
      logic irq_q;
      // Interrupt and flag held in separate registers, both active high
      always_ff @(posedge clk) begin
        if (rst) begin
          flag_q <= 1'b0;
          irq_q  <= 1'b0;
        end else if (hits_i.hit_start) begin
          flag_q <= 1'b1;
          irq_q  <= 1'b1;
        end else if (hits_i.hit_end) begin
          flag_q <= 1'b0;
          irq_q  <= 1'b0;
        end
      end
      assign flag_o = flag_q;
      assign irq_o  = irq_q;
    end else begin : g_flag
      logic flag_q;
      // Flag only, active low during predisplay; idle level is 1
      always_ff @(posedge clk) begin
        if (rst) begin
          flag_q <= 1'b1;
        end else if (hits_i.hit_start) begin
          flag_q <= 1'b0;
        end else if (hits_i.hit_end) begin
          flag_q <= 1'b1;
        end
      end
      assign flag_o = flag_q;
      assign irq_o  = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/prd_ef_pack.sv
module prd_ef_pack (
  input  logic       flag_i,
  input  logic       test_n_i,
  input  logic       coin2_n_i,
  input  logic       coin1_n_i,
  output logic [3:0] ef_o
);
  // Bit order is decoded by the processor's flag-branch instructions
  assign ef_o = {coin1_n_i, coin2_n_i, test_n_i, flag_i};
endmodule

// File: rtl/prd_boot_timer.sv
module prd_boot_timer #(
  parameter int BOOT_CYCLES = 715800
) (
  input  logic       clk,
  input  logic       rst,
  output logic [1:0] mode_o
);
  localparam int CNT_W = (BOOT_CYCLES < 2) ? 1 : $clog2(BOOT_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BOOT_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (!run_q) begin
      if (cnt_q == LAST) run_q <= 1'b1;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign mode_o = run_q ? prd_pkg::MODE_RUN : prd_pkg::MODE_HOLD;
endmodule

// File: rtl/prd_event_unit.sv
module prd_event_unit #(
  parameter int                    SCAN_W      = 9,
  parameter int                    PRD_START   = 283,
  parameter int                    PRD_END     = 301,
  parameter int                    BOOT_CYCLES = 715800,
  parameter prd_pkg::prd_variant_e VARIANT     = prd_pkg::PRD_RAISE_IRQ
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SCAN_W-1:0] scanline_i,
  input  logic              test_n_i,
  input  logic              coin1_n_i,
  input  logic              coin2_n_i,
  output logic              irq_o,
  output logic [3:0]        ef_o,
  output logic [1:0]        mode_o
);
  prd_pkg::prd_hits_t hits;
  logic               flag;

  prd_line_match #(
    .SCAN_W(SCAN_W), .PRD_START(PRD_START), .PRD_END(PRD_END)
  ) u_match (
    .scanline_i(scanline_i),
    .hits_o    (hits)
  );

  prd_edge_state #(.VARIANT(VARIANT)) u_state (
    .clk   (clk),
    .rst   (rst),
    .hits_i(hits),
    .flag_o(flag),
    .irq_o (irq_o)
  );

  prd_ef_pack u_ef (
    .flag_i   (flag),
    .test_n_i (test_n_i),
    .coin2_n_i(coin2_n_i),
    .coin1_n_i(coin1_n_i),
    .ef_o     (ef_o)
  );

  prd_boot_timer #(.BOOT_CYCLES(BOOT_CYCLES)) u_boot (
    .clk   (clk),
    .rst   (rst),
    .mode_o(mode_o)
  );
endmodule

// File: rtl/prd_event_unit_chk.sv
module prd_event_unit_chk #(
  parameter int                    SCAN_W      = 9,
  parameter int                    PRD_START   = 283,
  parameter int                    PRD_END     = 301,
  parameter int                    BOOT_CYCLES = 715800,
  parameter prd_pkg::prd_variant_e VARIANT     = prd_pkg::PRD_RAISE_IRQ
) (
  input logic              clk,
  input logic              rst,
  input logic [SCAN_W-1:0] scanline_i,
  input logic              irq_o,
  input logic [3:0]        ef_o,
  input logic [1:0]        mode_o
);
  localparam logic [SCAN_W-1:0] S_L = SCAN_W'(PRD_START);
  localparam logic [SCAN_W-1:0] E_L = SCAN_W'(PRD_END);
  localparam int CW = $clog2(BOOT_CYCLES + 1) + 1;
  localparam logic [CW-1:0] BOOT_L = CW'(BOOT_CYCLES);
  localparam bit IS_IRQ = (VARIANT == prd_pkg::PRD_RAISE_IRQ);

  logic [CW-1:0] seen_q;
  always_ff @(posedge clk) begin
    if (rst) seen_q <= '0;
    else if (seen_q != BOOT_L) seen_q <= seen_q + 1'b1;
  end

  a_r1_start_raises: assert property (@(posedge clk) disable iff (rst)
    (IS_IRQ && scanline_i == S_L) |=> (irq_o && ef_o[0]));

  a_r2_end_drops: assert property (@(posedge clk) disable iff (rst)
    (IS_IRQ && scanline_i == E_L) |=> (!irq_o && !ef_o[0]));

  a_r3_no_irq: assert property (@(posedge clk) disable iff (rst)
    !IS_IRQ |-> !irq_o);

  a_r4_flag_polarity: assert property (@(posedge clk) disable iff (rst)
    (!IS_IRQ && scanline_i == S_L) |=> !ef_o[0]);

  a_r5_hold_between: assert property (@(posedge clk) disable iff (rst)
    (scanline_i != S_L && scanline_i != E_L) |=> ($stable(ef_o[0]) && $stable(irq_o)));

  a_r7_boot_window: assert property (@(posedge clk) disable iff (rst)
    (mode_o == prd_pkg::MODE_RUN) == (seen_q == BOOT_L));

  a_r7_mode_legal: assert property (@(posedge clk) disable iff (rst)
    (mode_o == prd_pkg::MODE_RUN) || (mode_o == prd_pkg::MODE_HOLD));

  a_r8_reset_state: assert property (@(posedge clk)
    rst |=> (mode_o == prd_pkg::MODE_HOLD && !irq_o && (ef_o[0] == !IS_IRQ)));
endmodule

bind prd_event_unit prd_event_unit_chk #(
  .SCAN_W(SCAN_W), .PRD_START(PRD_START), .PRD_END(PRD_END),
  .BOOT_CYCLES(BOOT_CYCLES), .VARIANT(VARIANT)
) u_chk (
  .clk(clk), .rst(rst), .scanline_i(scanline_i),
  .irq_o(irq_o), .ef_o(ef_o), .mode_o(mode_o)
);

// File: tb/prd_event_unit_tb_top.sv
`timescale 1ns/1ps
module prd_event_unit_tb_top;
  localparam int SW = 5;
  localparam int ST = 20;
  localparam int EN = 26;
  localparam int BOOT = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [SW-1:0] line = '0;
  logic test_n = 1'b1, coin1_n = 1'b1, coin2_n = 1'b1;
  logic irq_a, irq_b;
  logic [3:0] ef_a, ef_b;
  logic [1:0] mode_a, mode_b;

  int checks = 0;
  int errors = 0;
  int edges = 0;
  bit done = 0;
  bit m_flag_a = 0;  // model, interrupt variant
  bit m_flag_b = 1;  // model, flag-only variant

  always #2 clk = ~clk;

  prd_event_unit #(.SCAN_W(SW), .PRD_START(ST), .PRD_END(EN),
    .BOOT_CYCLES(BOOT), .VARIANT(prd_pkg::PRD_RAISE_IRQ)) dut_i (
    .clk(clk), .rst(rst), .scanline_i(line), .test_n_i(test_n),
    .coin1_n_i(coin1_n), .coin2_n_i(coin2_n),
    .irq_o(irq_a), .ef_o(ef_a), .mode_o(mode_a));

  prd_event_unit #(.SCAN_W(SW), .PRD_START(ST), .PRD_END(EN),
    .BOOT_CYCLES(BOOT), .VARIANT(prd_pkg::PRD_FLAG_ONLY)) dut_f (
    .clk(clk), .rst(rst), .scanline_i(line), .test_n_i(test_n),
    .coin1_n_i(coin1_n), .coin2_n_i(coin2_n),
    .irq_o(irq_b), .ef_o(ef_b), .mode_o(mode_b));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d line=%0d t=%0t", req, act, exp, line, $time);
    end
  endtask

  task automatic check_all();
    int exp_mode;
    exp_mode = (edges >= BOOT) ? 3 : 1;
    check("R7 mode interrupt variant", mode_a, exp_mode);
    check("R7 mode flag variant", mode_b, exp_mode);
    check("R1 R2 R5 irq", irq_a, m_flag_a);
    check("R1 R2 R5 ef0", ef_a[0], m_flag_a);
    check("R3 irq stays low", irq_b, 0);
    check("R4 R5 ef0 flag-only", ef_b[0], m_flag_b);
    check("R6 ef upper bits", ef_a[3:1], {coin1_n, coin2_n, test_n});
    check("R6 ef upper bits flag-only", ef_b[3:1], {coin1_n, coin2_n, test_n});
  endtask

  // One clock: inputs were driven at the preceding negedge
  task automatic tick();
    @(posedge clk);
    if (rst) begin
      edges = 0; m_flag_a = 0; m_flag_b = 1;
    end else begin
      edges++;
      if (line == SW'(ST)) begin m_flag_a = 1; m_flag_b = 0; end
      else if (line == SW'(EN)) begin m_flag_a = 0; m_flag_b = 1; end
    end
    @(negedge clk);
    check_all();
  endtask

  task automatic drive(input int l, input int pins);
    line = SW'(l);
    {coin1_n, coin2_n, test_n} = 3'(pins);
    tick();
  endtask

  initial begin
    repeat (3) tick();
    // R8 reset state
    check("R8 mode at reset", mode_a, 1);
    check("R8 ef0 flag-only at reset", ef_b[0], 1);
    check("R8 irq at reset", irq_a, 0);
    rst = 1'b0;
    // Full frames with all pin patterns, crossing the boot window
    for (int f = 0; f < 4; f++)
      for (int l = 0; l < 32; l++) drive(l, l + f);
    // Odd orders: start twice, end without start, end twice
    drive(ST, 5); drive(3, 2); drive(ST, 1); drive(EN, 0);
    drive(EN, 7); drive(9, 4); drive(ST, 6); drive(31, 3);
    // Reset inside predisplay, then recount the window (R8, R7)
    drive(ST, 2);
    check("R1 flag set before reset", ef_a[0], 1);
    rst = 1'b1; line = SW'(22);
    tick(); tick();
    check("R8 irq cleared by reset", irq_a, 0);
    check("R8 mode back to hold", mode_a, 1);
    rst = 1'b0;
    for (int k = 0; k < BOOT + 10; k++) drive(k % 32, k);
    // Hold one non-event line for many cycles (R5)
    for (int k = 0; k < 20; k++) drive(12, k);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule